// File: doc/BRIEF.md
# Operating Mode Clock Gating Controller

This controller sits at system level and decides which of five operating modes the chip is in: reset, run, debug, wait or stop. It turns reset sources, mode entry requests and wake-up events into one global peripheral reset, a set of registered clock enables and two control outputs. The enables cover the core, the memories, the watchdog, the CAN controller and the remaining peripherals. The control outputs are a PWM output-disable and a PLL enable.

There are four reset sources: the power-on reset, the external reset pin, a watchdog reset and a software reset request. All four put every block back into reset. They differ in how they treat the two-bit boot-mode field. After a power-on or pin reset the field reloads from a strap input. After a watchdog or software reset it keeps its earlier value, so the next boot can follow a choice made before the reset.

Each low-power mode has its own gating options, chosen by static configuration inputs. These cover the watchdog, the CAN clock and the PWM outputs. The PLL enable follows an explicit software bit and is never dropped automatically when the chip enters stop.

Top module: `opmode_clkgate_ctrl`

## Requirements
- R1: A low on `rst_pin_n`, or a power-on reset, drives `periph_rst_n` low and `mode` to 0 (reset). While reset is held, `boot_mode` loads the value on `boot_strap`.
- R2: `periph_rst_n` goes high on the 16th rising edge after the last synchronous reset source is sampled inactive. `mode` changes to 1 (run) on that same edge. When `por_n` is released, two synchronizer edges come before that count.
- R3: A pulse on `wdog_rst` or `sw_rst` runs the same reset sequence as R2 but leaves `boot_mode` unchanged, whatever `boot_strap` holds.
- R4: In run (mode 1), all five clock enables are 1 and `pwm_disable` is 0.
- R5: From run, requests are sampled on a rising edge. `mode` and all gating outputs move on that same edge. Priority: debug (2) before stop (4) before wait (3).
- R6: In debug, `wdog_ce` is 0, the other enables are 1, and `pwm_disable` equals `cfg_pwm_off_dbg`. Debug returns to run on the first edge where `dbg_req` is low.
- R7: In wait (3), `core_ce` and `mem_ce` are 0 and `can_ce` and `periph_ce` are 1. `wdog_ce` is the inverse of `cfg_wdog_wait_off` and `pwm_disable` equals `cfg_pwm_off_wait`. Wait goes to debug on `dbg_req`. Otherwise it goes to run on `irq_pending`.
- R8: In stop (4), `core_ce`, `mem_ce` and `periph_ce` are 0 and `pwm_disable` is 1. `wdog_ce` is the inverse of `cfg_wdog_stop_off` and `can_ce` is the inverse of `cfg_can_stop_off`. Stop ignores debug and wait requests and returns to run only on `can_wake` or `irq_pending`.
- R9: `pll_en` is 1 while in reset. Otherwise it takes `pll_en_sw` one edge later, in every mode, including on entry to stop.
- R10: In reset mode, all clock enables are 1 and `pwm_disable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_pin_n | input | 1 | External reset pin, active low, synchronous to clk |
| wdog_rst | input | 1 | Watchdog reset request |
| sw_rst | input | 1 | Software reset request |
| boot_strap | input | 2 | Boot-mode value loaded on hard resets |
| dbg_req | input | 1 | Debug mode request, held for the whole debug session |
| wait_req | input | 1 | Wait mode entry request |
| stop_req | input | 1 | Stop mode entry request |
| irq_pending | input | 1 | An enabled, ungated interrupt is pending |
| can_wake | input | 1 | CAN wake-up activity |
| cfg_wdog_wait_off | input | 1 | Stop watchdog clock in wait |
| cfg_wdog_stop_off | input | 1 | Stop watchdog clock in stop |
| cfg_can_stop_off | input | 1 | Stop CAN clock in stop |
| cfg_pwm_off_dbg | input | 1 | Disable PWM outputs in debug |
| cfg_pwm_off_wait | input | 1 | Disable PWM outputs in wait |
| pll_en_sw | input | 1 | Software PLL enable bit |
| periph_rst_n | output | 1 | Global core/peripheral reset, active low |
| core_ce | output | 1 | Core clock enable |
| mem_ce | output | 1 | Memory clock enable |
| wdog_ce | output | 1 | Watchdog clock enable |
| can_ce | output | 1 | CAN clock enable |
| periph_ce | output | 1 | Enable for the remaining peripheral clocks |
| pwm_disable | output | 1 | Force PWM outputs off |
| pll_en | output | 1 | PLL enable |
| boot_mode | output | 2 | Retained boot-mode field |
| mode | output | 3 | Current mode: 0 reset, 1 run, 2 debug, 3 wait, 4 stop |

## Verification
The assertions assume that every input other than `por_n` is already synchronous to `clk`. They also assume the configuration bits are stable whenever a mode is checked. The stimulus meets both assumptions by changing every input, `por_n` included, only on the falling clock edge. Configuration bits are changed only while the controller sits in run. The sweep covers all 32 combinations of the five option bits in each low-power mode. The boot strap is changed only between reset sequences, so a kept or reloaded `boot_mode` can be told apart.

// File: rtl/opm_pkg.sv
package opm_pkg;

  typedef enum logic [2:0] {
    OPM_RESET = 3'd0,
    OPM_RUN   = 3'd1,
    OPM_DEBUG = 3'd2,
    OPM_WAIT  = 3'd3,
    OPM_STOP  = 3'd4
  } opm_mode_e;

  typedef struct packed {
    logic wdog_wait_off;
    logic wdog_stop_off;
    logic can_stop_off;
    logic pwm_off_dbg;
    logic pwm_off_wait;
  } opm_cfg_t;

  typedef struct packed {
    logic core;
    logic mem;
    logic wdog;
    logic can;
    logic periph;
    logic pwm_dis;
  } opm_gate_t;

  localparam opm_gate_t OPM_GATE_RESET = '{core: 1'b1, mem: 1'b1, wdog: 1'b1,
                                           can: 1'b1, periph: 1'b1, pwm_dis: 1'b1};

endpackage

// File: rtl/opm_rst_seq.sv
module opm_rst_seq #(
  parameter int RST_HOLD = 16,
  parameter int BOOT_W   = 2
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic              rst_pin_n,
  input  logic              wdog_rst,
  input  logic              sw_rst,
  input  logic [BOOT_W-1:0] strap,
  output logic              rst_next,
  output logic              in_rst_q,
  output logic [BOOT_W-1:0] boot_q
);

  localparam int CNT_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_HOLD - 1);

  logic             pin_rst;
  logic             src;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;
  logic             hard_q, hard_nxt;
  logic [BOOT_W-1:0] boot_nxt;
  logic             boot_en;

  assign pin_rst = ~rst_pin_n;
  assign src     = pin_rst | wdog_rst | sw_rst;

  always_comb begin
    rst_next = src | (in_rst_q & (cnt_q != CNT_LAST));
    cnt_en   = src | in_rst_q;
    cnt_nxt  = cnt_q;
    if (src) begin
      cnt_nxt = '0;
    end else if (in_rst_q) begin
      cnt_nxt = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
    end
    hard_nxt = pin_rst | (rst_next & hard_q);
    boot_en  = hard_q & in_rst_q;
    boot_nxt = boot_en ? strap : boot_q;
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      in_rst_q <= 1'b1;
      cnt_q    <= '0;
      hard_q   <= 1'b1;
      boot_q   <= '0;
    end else begin
      in_rst_q <= rst_next;
      if (cnt_en)  cnt_q  <= cnt_nxt;
      hard_q   <= hard_nxt;
      if (boot_en) boot_q <= boot_nxt;
    end
  end

  // R1
  src_sets_reset_chk: assert property (@(posedge clk) disable iff (!rstn)
    src |=> in_rst_q);

  // R2
  rst_release_chk: assert property (@(posedge clk) disable iff (!rstn)
    $fell(in_rst_q) |-> ($past(cnt_q) == CNT_LAST && !$past(src)));

  // R3
  boot_keep_chk: assert property (@(posedge clk) disable iff (!rstn)
    ((wdog_rst | sw_rst) && rst_pin_n && !hard_q) |=> (boot_q == $past(boot_q)));

endmodule

// File: rtl/opm_mode_fsm.sv
module opm_mode_fsm
  import opm_pkg::*;
(
  input  logic      clk,
  input  logic      rstn,
  input  logic      rst_next,
  input  logic      dbg_req,
  input  logic      wait_req,
  input  logic      stop_req,
  input  logic      irq_pending,
  input  logic      can_wake,
  output opm_mode_e mode_nxt,
  output opm_mode_e mode_q
);

  always_comb begin
    mode_nxt = mode_q;
    if (rst_next) begin
      mode_nxt = OPM_RESET;
    end else begin
      case (mode_q)
        OPM_RESET: mode_nxt = OPM_RUN;
        OPM_RUN: begin
          if (dbg_req)       mode_nxt = OPM_DEBUG;
          else if (stop_req) mode_nxt = OPM_STOP;
          else if (wait_req) mode_nxt = OPM_WAIT;
        end
        OPM_DEBUG: begin
          if (!dbg_req) mode_nxt = OPM_RUN;
        end
        OPM_WAIT: begin
          if (dbg_req)          mode_nxt = OPM_DEBUG;
          else if (irq_pending) mode_nxt = OPM_RUN;
        end
        OPM_STOP: begin
          if (can_wake | irq_pending) mode_nxt = OPM_RUN;
        end
        default: mode_nxt = OPM_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) mode_q <= OPM_RESET;
    else       mode_q <= mode_nxt;
  end

  // R5
  dbg_priority_chk: assert property (@(posedge clk) disable iff (!rstn)
    (mode_q == OPM_RUN && dbg_req && !rst_next) |=> (mode_q == OPM_DEBUG));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstn)
    (mode_q == OPM_STOP && !can_wake && !irq_pending && !rst_next) |=> (mode_q == OPM_STOP));

endmodule

// File: rtl/opm_gate_out.sv
module opm_gate_out
  import opm_pkg::*;
(
  input  logic      clk,
  input  logic      rstn,
  input  opm_mode_e mode_nxt,
  input  opm_mode_e mode_q,
  input  opm_cfg_t  cfg,
  input  logic      rst_next,
  input  logic      pll_en_sw,
  output opm_gate_t gate_q,
  output logic      pll_en_q
);

  opm_gate_t gate_nxt;
  logic      pll_nxt;

  always_comb begin
    gate_nxt = OPM_GATE_RESET;
    case (mode_nxt)
      OPM_RUN: begin
        gate_nxt.pwm_dis = 1'b0;
      end
      OPM_DEBUG: begin
        gate_nxt.wdog    = 1'b0;
        gate_nxt.pwm_dis = cfg.pwm_off_dbg;
      end
      OPM_WAIT: begin
        gate_nxt.core    = 1'b0;
        gate_nxt.mem     = 1'b0;
        gate_nxt.wdog    = ~cfg.wdog_wait_off;
        gate_nxt.pwm_dis = cfg.pwm_off_wait;
      end
      OPM_STOP: begin
        gate_nxt.core    = 1'b0;
        gate_nxt.mem     = 1'b0;
        gate_nxt.periph  = 1'b0;
        gate_nxt.wdog    = ~cfg.wdog_stop_off;
        gate_nxt.can     = ~cfg.can_stop_off;
        gate_nxt.pwm_dis = 1'b1;
      end
      default: gate_nxt = OPM_GATE_RESET;
    endcase
    pll_nxt = rst_next | pll_en_sw;
  end

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      gate_q   <= OPM_GATE_RESET;
      pll_en_q <= 1'b1;
    end else begin
      gate_q   <= gate_nxt;
      pll_en_q <= pll_nxt;
    end
  end

  // R4
  run_all_on_chk: assert property (@(posedge clk) disable iff (!rstn)
    (mode_q == OPM_RUN) |-> (gate_q.core && gate_q.mem && gate_q.wdog &&
                             gate_q.can && gate_q.periph && !gate_q.pwm_dis));

  // R6
  dbg_wdog_chk: assert property (@(posedge clk) disable iff (!rstn)
    (mode_q == OPM_DEBUG) |-> (!gate_q.wdog && gate_q.core));

  // R7
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rstn)
    (mode_q == OPM_WAIT) |-> (!gate_q.core && !gate_q.mem && gate_q.periph));

  // R9
  stop_pll_chk: assert property (@(posedge clk) disable iff (!rstn)
    $rose(mode_q == OPM_STOP) |-> (pll_en_q == $past(pll_en_sw)));

endmodule

// File: rtl/opmode_clkgate_ctrl.sv
module opmode_clkgate_ctrl
  import opm_pkg::*;
#(
  parameter int RST_HOLD = 16,
  parameter int RST_SYNC = 2,
  parameter int BOOT_W   = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              wdog_rst,
  input  logic              sw_rst,
  input  logic [BOOT_W-1:0] boot_strap,
  input  logic              dbg_req,
  input  logic              wait_req,
  input  logic              stop_req,
  input  logic              irq_pending,
  input  logic              can_wake,
  input  logic              cfg_wdog_wait_off,
  input  logic              cfg_wdog_stop_off,
  input  logic              cfg_can_stop_off,
  input  logic              cfg_pwm_off_dbg,
  input  logic              cfg_pwm_off_wait,
  input  logic              pll_en_sw,
  output logic              periph_rst_n,
  output logic              core_ce,
  output logic              mem_ce,
  output logic              wdog_ce,
  output logic              can_ce,
  output logic              periph_ce,
  output logic              pwm_disable,
  output logic              pll_en,
  output logic [BOOT_W-1:0] boot_mode,
  output logic [2:0]        mode
);

  logic [RST_SYNC-1:0] por_sync_q;
  logic                rstn;
  logic                rst_next;
  logic                in_rst_q;
  opm_mode_e           mode_nxt, mode_q;
  opm_cfg_t            cfg;
  opm_gate_t           gate_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_sync_q <= '0;
    else        por_sync_q <= {por_sync_q[RST_SYNC-2:0], 1'b1};
  end
  assign rstn = por_sync_q[RST_SYNC-1];

  assign cfg = '{wdog_wait_off: cfg_wdog_wait_off, wdog_stop_off: cfg_wdog_stop_off,
                 can_stop_off: cfg_can_stop_off, pwm_off_dbg: cfg_pwm_off_dbg,
                 pwm_off_wait: cfg_pwm_off_wait};

  opm_rst_seq #(.RST_HOLD(RST_HOLD), .BOOT_W(BOOT_W)) i_rst_seq (
    .clk       (clk),
    .rstn      (rstn),
    .rst_pin_n (rst_pin_n),
    .wdog_rst  (wdog_rst),
    .sw_rst    (sw_rst),
    .strap     (boot_strap),
    .rst_next  (rst_next),
    .in_rst_q  (in_rst_q),
    .boot_q    (boot_mode)
  );

  opm_mode_fsm i_mode_fsm (
    .clk         (clk),
    .rstn        (rstn),
    .rst_next    (rst_next),
    .dbg_req     (dbg_req),
    .wait_req    (wait_req),
    .stop_req    (stop_req),
    .irq_pending (irq_pending),
    .can_wake    (can_wake),
    .mode_nxt    (mode_nxt),
    .mode_q      (mode_q)
  );

  opm_gate_out i_gate_out (
    .clk       (clk),
    .rstn      (rstn),
    .mode_nxt  (mode_nxt),
    .mode_q    (mode_q),
    .cfg       (cfg),
    .rst_next  (rst_next),
    .pll_en_sw (pll_en_sw),
    .gate_q    (gate_q),
    .pll_en_q  (pll_en)
  );

  assign periph_rst_n = ~in_rst_q;
  assign core_ce      = gate_q.core;
  assign mem_ce       = gate_q.mem;
  assign wdog_ce      = gate_q.wdog;
  assign can_ce       = gate_q.can;
  assign periph_ce    = gate_q.periph;
  assign pwm_disable  = gate_q.pwm_dis;
  assign mode         = mode_q;

  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rstn)
    !periph_rst_n |-> (mode_q == OPM_RESET));

endmodule

// File: tb/test_opmode_clkgate_ctrl.sv
module test_opmode_clkgate_ctrl;

  logic clk = 1'b0;
  logic por_n, rst_pin_n, wdog_rst, sw_rst;
  logic [1:0] boot_strap;
  logic dbg_req, wait_req, stop_req, irq_pending, can_wake;
  logic cfg_wdog_wait_off, cfg_wdog_stop_off, cfg_can_stop_off, cfg_pwm_off_dbg, cfg_pwm_off_wait;
  logic pll_en_sw;
  logic periph_rst_n, core_ce, mem_ce, wdog_ce, can_ce, periph_ce, pwm_disable, pll_en;
  logic [1:0] boot_mode;
  logic [2:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  opmode_clkgate_ctrl i_opmode_clkgate_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdog_rst(wdog_rst), .sw_rst(sw_rst),
    .boot_strap(boot_strap), .dbg_req(dbg_req), .wait_req(wait_req), .stop_req(stop_req),
    .irq_pending(irq_pending), .can_wake(can_wake),
    .cfg_wdog_wait_off(cfg_wdog_wait_off), .cfg_wdog_stop_off(cfg_wdog_stop_off),
    .cfg_can_stop_off(cfg_can_stop_off), .cfg_pwm_off_dbg(cfg_pwm_off_dbg),
    .cfg_pwm_off_wait(cfg_pwm_off_wait), .pll_en_sw(pll_en_sw),
    .periph_rst_n(periph_rst_n), .core_ce(core_ce), .mem_ce(mem_ce), .wdog_ce(wdog_ce),
    .can_ce(can_ce), .periph_ce(periph_ce), .pwm_disable(pwm_disable), .pll_en(pll_en),
    .boot_mode(boot_mode), .mode(mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] gates_now();
    return {core_ce, mem_ce, wdog_ce, can_ce, periph_ce, pwm_disable};
  endfunction

  // expected {core,mem,wdog,can,periph,pwm_disable} per mode code
  function automatic logic [5:0] exp_gates(input int m, input logic [4:0] c);
    case (m)
      0: return 6'b111111;
      1: return 6'b111110;
      2: return {3'b110, 2'b11, c[3]};
      3: return {2'b00, ~c[0], 2'b11, c[4]};
      4: return {2'b00, ~c[1], ~c[2], 1'b0, 1'b1};
      default: return 6'b000000;
    endcase
  endfunction

  task automatic set_cfg(input logic [4:0] c);
    cfg_wdog_wait_off = c[0];
    cfg_wdog_stop_off = c[1];
    cfg_can_stop_off  = c[2];
    cfg_pwm_off_dbg   = c[3];
    cfg_pwm_off_wait  = c[4];
  endtask

  // release at the current falling edge, then count rising edges
  task automatic count_release(input string req, input int edges);
    for (int k = 1; k <= edges; k++) begin
      @(negedge clk);
      check(req, int'(periph_rst_n), (k >= edges) ? 1 : 0);
    end
    check(req, int'(mode), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_pin_n = 1'b1; wdog_rst = 1'b0; sw_rst = 1'b0;
    boot_strap = 2'b10; dbg_req = 1'b0; wait_req = 1'b0; stop_req = 1'b0;
    irq_pending = 1'b0; can_wake = 1'b0; pll_en_sw = 1'b1;
    set_cfg(5'd0);
    repeat (3) @(negedge clk);
    check("R1 reset low", int'(periph_rst_n), 0);
    check("R1 mode reset", int'(mode), 0);
    check("R10 reset gates", int'(gates_now()), int'(exp_gates(0, 5'd0)));
    check("R9 pll in reset", int'(pll_en), 1);
    por_n = 1'b1;
    count_release("R2 por release", 18);
    check("R1 boot strap load", int'(boot_mode), 2);
    check("R4 run gates", int'(gates_now()), int'(exp_gates(1, 5'd0)));

    for (int ci = 0; ci < 32; ci++) begin
      logic [4:0] c;
      c = 5'(ci);
      set_cfg(c);
      @(negedge clk);
      check("R4 run gates", int'(gates_now()), int'(exp_gates(1, c)));
      dbg_req = 1'b1;
      @(negedge clk);
      check("R6 debug mode", int'(mode), 2);
      check("R6 debug gates", int'(gates_now()), int'(exp_gates(2, c)));
      dbg_req = 1'b0;
      @(negedge clk);
      check("R6 debug exit", int'(mode), 1);
      wait_req = 1'b1;
      @(negedge clk);
      wait_req = 1'b0;
      check("R7 wait mode", int'(mode), 3);
      check("R7 wait gates", int'(gates_now()), int'(exp_gates(3, c)));
      @(negedge clk);
      check("R7 wait holds", int'(mode), 3);
      irq_pending = 1'b1;
      @(negedge clk);
      irq_pending = 1'b0;
      check("R7 wait exit", int'(mode), 1);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      check("R8 stop mode", int'(mode), 4);
      check("R8 stop gates", int'(gates_now()), int'(exp_gates(4, c)));
      dbg_req = 1'b1; wait_req = 1'b1;
      @(negedge clk);
      dbg_req = 1'b0; wait_req = 1'b0;
      check("R8 stop ignores requests", int'(mode), 4);
      check("R8 stop gates held", int'(gates_now()), int'(exp_gates(4, c)));
      if (ci % 2 == 0) can_wake = 1'b1; else irq_pending = 1'b1;
      @(negedge clk);
      can_wake = 1'b0; irq_pending = 1'b0;
      check("R8 stop wake", int'(mode), 1);
      check("R4 run gates after wake", int'(gates_now()), int'(exp_gates(1, c)));
    end

    // R5 priority
    set_cfg(5'd0);
    dbg_req = 1'b1; stop_req = 1'b1; wait_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0; wait_req = 1'b0;
    check("R5 debug first", int'(mode), 2);
    dbg_req = 1'b0;
    @(negedge clk);
    stop_req = 1'b1; wait_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0; wait_req = 1'b0;
    check("R5 stop before wait", int'(mode), 4);
    irq_pending = 1'b1;
    @(negedge clk);
    irq_pending = 1'b0;
    wait_req = 1'b1;
    @(negedge clk);
    wait_req = 1'b0;
    check("R5 wait entry", int'(mode), 3);
    dbg_req = 1'b1; irq_pending = 1'b1;
    @(negedge clk);
    irq_pending = 1'b0;
    check("R7 debug over irq in wait", int'(mode), 2);
    dbg_req = 1'b0;
    @(negedge clk);

    // R9 PLL follows software bit only
    pll_en_sw = 1'b0;
    @(negedge clk);
    check("R9 pll off", int'(pll_en), 0);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R9 pll off in stop", int'(pll_en), 0);
    pll_en_sw = 1'b1;
    @(negedge clk);
    check("R9 pll on in stop", int'(pll_en), 1);

    // R1 pin reset from stop, new strap
    boot_strap = 2'b01;
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pin reset low", int'(periph_rst_n), 0);
    check("R1 pin reset mode", int'(mode), 0);
    check("R10 pin reset gates", int'(gates_now()), int'(exp_gates(0, 5'd0)));
    rst_pin_n = 1'b1;
    count_release("R2 pin release", 16);
    check("R1 boot reload", int'(boot_mode), 1);

    // R3 watchdog and software resets keep the boot field
    boot_strap = 2'b11;
    wdog_rst = 1'b1;
    @(negedge clk);
    check("R3 wdog reset low", int'(periph_rst_n), 0);
    wdog_rst = 1'b0;
    count_release("R3 wdog release", 16);
    check("R3 boot kept wdog", int'(boot_mode), 1);
    boot_strap = 2'b00;
    sw_rst = 1'b1;
    @(negedge clk);
    check("R3 sw reset mode", int'(mode), 0);
    sw_rst = 1'b0;
    count_release("R3 sw release", 16);
    check("R3 boot kept sw", int'(boot_mode), 1);

    finish_run();
  end

endmodule